// File: doc/BRIEF.md
# Performance Event to Counter Mapper

This block keeps the association between hardware event identifiers and the programmable performance counters of a core. Software-side logic presents a counter index together with an event-selector value on a write port. The block checks that the counter is one of the configured programmable ones and that the event is one it knows. It then records which counter each event feeds. An event is bound to at most one counter, and the first binding wins until it is removed. Writing an all-zero selector to a counter unbinds every event that targets that counter.

Event sources use the lookup port. They present a 20-bit event identifier and get back, in the same cycle, whether a counter is bound to it and which one. Index 0 stands for "unbound". A third port answers, for a given counter index, whether that counter counts cycles or retired instructions. Counters 0 and 2 are fixed to those roles. Any other counter reports a role only while the matching event is bound to it. The table lives in one register per supported event, so all lookups are parallel compares.

Top module: `evt_ctr_mapper`

## Requirements
- R1: After reset no event is bound: every lookup returns hit 0 with counter 0, counters 3 to 6 report neither role, and the error output is 0.
- R2: A write of a supported, unbound event to a valid counter binds it. From the next cycle a lookup of that event returns hit 1 and that counter, and the error output stays 0.
- R3: With the default four programmable counters, only indices 3 to 6 are valid. A write to any other index raises the error output for exactly one cycle after the write edge and changes no binding.
- R4: Only event codes 0x00001 (cycles), 0x00002 (instructions), 0x10019 (data-TLB read miss), 0x1001B (data-TLB write miss) and 0x10021 (instruction-TLB miss) are supported. A non-zero write of any other code raises the error output and binds nothing.
- R5: A write of an event that is already bound is ignored without error, and the earlier binding is kept.
- R6: An all-zero selector written to a valid counter removes every binding to that counter, raises no error, and leaves bindings to other counters intact.
- R7: Counter 0 always reports the cycles role and counter 2 always reports the instructions role.
- R8: Any other counter reports the cycles or instructions role only while event 0x00001 or 0x00002, respectively, is bound to it.
- R9: The lookup hit output is 1 exactly when the returned counter index is non-zero. An unsupported identifier always misses.
- R10: Several events may be bound to the same counter at once.
- R11: Only selector bits [19:0] form the event identifier. Bits above 19 are ignored for a non-zero selector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write strobe |
| wrCtr | input | 5 | Counter index of the write |
| wrSel | input | 32 | Event-selector value; [19:0] is the event identifier |
| wrErr | output | 1 | One-cycle error pulse for a rejected write |
| lookupEvt | input | 20 | Event identifier to resolve |
| lookupHit | output | 1 | A counter is bound to lookupEvt |
| lookupCtr | output | 5 | Bound counter index, 0 when unbound |
| queryCtr | input | 5 | Counter index whose role is asked |
| queryIsCycles | output | 1 | queryCtr counts cycles |
| queryIsInstr | output | 1 | queryCtr counts retired instructions |

## Verification
Lookup and role results are combinational from the table and the query inputs. A write changes the table at its clock edge, and the error pulse is registered at that same edge and lasts one cycle. The bench drives a write on a falling edge and lets one rising edge pass. On the next falling edge it drops the strobe and samples wrErr, then applies lookups and role queries, so every result is read in the half-cycle after the edge that produced it. One extra idle cycle confirms that the error pulse has ended.

// File: rtl/evt_map_pkg.sv
package evt_map_pkg;

  localparam int EVT_W   = 20;
  localparam int N_SLOTS = 5;

  localparam logic [EVT_W-1:0] EV_CYCLES  = 20'h00001;
  localparam logic [EVT_W-1:0] EV_INSTR   = 20'h00002;
  localparam logic [EVT_W-1:0] EV_DTLB_RD = 20'h10019;
  localparam logic [EVT_W-1:0] EV_DTLB_WR = 20'h1001B;
  localparam logic [EVT_W-1:0] EV_ITLB    = 20'h10021;

  typedef enum logic [2:0] {
    SLOT_CYC = 3'd0,
    SLOT_INS = 3'd1,
    SLOT_DRD = 3'd2,
    SLOT_DWR = 3'd3,
    SLOT_IPF = 3'd4
  } slot_e;

  typedef struct packed {
    logic  ok;
    slot_e slot;
  } slotDec_t;

  // strobes from control to datapath
  typedef struct packed {
    logic  setEn;
    logic  clrEn;
    logic  err;
    slot_e slot;
  } strobe_t;

  function automatic slotDec_t decodeEvt(input logic [EVT_W-1:0] evt);
    slotDec_t d;
    d.ok   = 1'b1;
    d.slot = SLOT_CYC;
    case (evt)
      EV_CYCLES:  d.slot = SLOT_CYC;
      EV_INSTR:   d.slot = SLOT_INS;
      EV_DTLB_RD: d.slot = SLOT_DRD;
      EV_DTLB_WR: d.slot = SLOT_DWR;
      EV_ITLB:    d.slot = SLOT_IPF;
      default:    d.ok   = 1'b0;
    endcase
    return d;
  endfunction

endpackage

// File: rtl/evt_map_ctrl.sv
module evt_map_ctrl
  import evt_map_pkg::*;
#(
  parameter int MAX_CTRS = 32,
  parameter int NUM_PROG = 4,
  parameter int SEL_W    = 32,
  parameter int CW       = $clog2(MAX_CTRS)
) (
  input  logic               wrEn,
  input  logic [CW-1:0]      wrCtr,
  input  logic [SEL_W-1:0]   wrSel,
  input  logic [N_SLOTS-1:0] slotUsed,
  output strobe_t            stb
);

  localparam int  FIRST_PROG = 3;
  localparam bit  CFG_OK     = (NUM_PROG >= 1) && (NUM_PROG <= MAX_CTRS - FIRST_PROG);

  function automatic logic [MAX_CTRS-1:0] buildAvail();
    logic [MAX_CTRS-1:0] m = '0;
    for (int i = 0; i < MAX_CTRS; i++) begin
      if (CFG_OK && i >= FIRST_PROG && i < FIRST_PROG + NUM_PROG) m[i] = 1'b1;
    end
    return m;
  endfunction

  localparam logic [MAX_CTRS-1:0] AVAIL = buildAvail();

  logic     ctrValid;
  logic     selZero;
  slotDec_t dec;

  always_comb begin
    ctrValid = (int'(wrCtr) < MAX_CTRS) && AVAIL[wrCtr];
    selZero  = (wrSel == '0);
    dec      = decodeEvt(wrSel[EVT_W-1:0]);
  end

  always_comb begin
    stb      = '0;
    stb.slot = dec.slot;
    if (wrEn) begin
      if (!ctrValid) begin
        stb.err = 1'b1;
      end else if (selZero) begin
        stb.clrEn = 1'b1;
      end else if (!dec.ok) begin
        stb.err = 1'b1;
      end else if (!slotUsed[dec.slot]) begin
        stb.setEn = 1'b1;
      end
    end
  end

endmodule

// File: rtl/evt_map_dpath.sv
module evt_map_dpath
  import evt_map_pkg::*;
#(
  parameter int CW = 5
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            stb,
  input  logic [CW-1:0]      wrCtr,
  output logic [N_SLOTS-1:0] slotUsed,
  output logic               wrErr,
  input  logic [EVT_W-1:0]   lookupEvt,
  output logic               lookupHit,
  output logic [CW-1:0]      lookupCtr,
  input  logic [CW-1:0]      queryCtr,
  output logic               queryIsCycles,
  output logic               queryIsInstr
);

  localparam logic [CW-1:0] FIXED_CYC = CW'(0);
  localparam logic [CW-1:0] FIXED_INS = CW'(2);

  logic [CW-1:0] slotCtr [N_SLOTS];
  slotDec_t      lookDec;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int s = 0; s < N_SLOTS; s++) slotCtr[s] <= '0;
      wrErr <= 1'b0;
    end else begin
      wrErr <= stb.err;
      for (int s = 0; s < N_SLOTS; s++) begin
        if (stb.clrEn && slotCtr[s] == wrCtr) begin
          slotCtr[s] <= '0;
        end else if (stb.setEn && int'(stb.slot) == s) begin
          slotCtr[s] <= wrCtr;
        end
      end
    end
  end

  always_comb begin
    for (int s = 0; s < N_SLOTS; s++) slotUsed[s] = (slotCtr[s] != '0);
    lookDec   = decodeEvt(lookupEvt);
    lookupCtr = lookDec.ok ? slotCtr[lookDec.slot] : '0;
    lookupHit = (lookupCtr != '0);
    queryIsCycles = (queryCtr == FIXED_CYC) ||
                    (slotUsed[SLOT_CYC] && slotCtr[SLOT_CYC] == queryCtr);
    queryIsInstr  = (queryCtr == FIXED_INS) ||
                    (slotUsed[SLOT_INS] && slotCtr[SLOT_INS] == queryCtr);
  end

endmodule

// File: rtl/evt_ctr_mapper.sv
module evt_ctr_mapper
  import evt_map_pkg::*;
#(
  parameter int MAX_CTRS = 32,
  parameter int NUM_PROG = 4,
  parameter int SEL_W    = 32,
  localparam int CW      = $clog2(MAX_CTRS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [CW-1:0]    wrCtr,
  input  logic [SEL_W-1:0] wrSel,
  output logic             wrErr,
  input  logic [EVT_W-1:0] lookupEvt,
  output logic             lookupHit,
  output logic [CW-1:0]    lookupCtr,
  input  logic [CW-1:0]    queryCtr,
  output logic             queryIsCycles,
  output logic             queryIsInstr
);

  strobe_t            stb;
  logic [N_SLOTS-1:0] slotUsed;

  evt_map_ctrl #(
    .MAX_CTRS(MAX_CTRS), .NUM_PROG(NUM_PROG), .SEL_W(SEL_W), .CW(CW)
  ) ctrl (
    .wrEn(wrEn), .wrCtr(wrCtr), .wrSel(wrSel), .slotUsed(slotUsed), .stb(stb)
  );

  evt_map_dpath #(.CW(CW)) dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .wrCtr(wrCtr), .slotUsed(slotUsed),
    .wrErr(wrErr), .lookupEvt(lookupEvt), .lookupHit(lookupHit),
    .lookupCtr(lookupCtr), .queryCtr(queryCtr),
    .queryIsCycles(queryIsCycles), .queryIsInstr(queryIsInstr)
  );

endmodule

// File: rtl/evt_ctr_mapper_chk.sv
module evt_ctr_mapper_chk
  import evt_map_pkg::*;
#(
  parameter int MAX_CTRS = 32,
  parameter int NUM_PROG = 4,
  parameter int SEL_W    = 32,
  parameter int CW       = 5
) (
  input logic             clk,
  input logic             rstN,
  input logic             wrEn,
  input logic [CW-1:0]    wrCtr,
  input logic [SEL_W-1:0] wrSel,
  input logic             wrErr,
  input logic [EVT_W-1:0] lookupEvt,
  input logic             lookupHit,
  input logic [CW-1:0]    lookupCtr,
  input logic [CW-1:0]    queryCtr,
  input logic             queryIsCycles,
  input logic             queryIsInstr
);

  logic     inRange;
  logic     zeroWr;
  slotDec_t wDec;

  always_comb begin
    inRange = (int'(wrCtr) >= 3) && (int'(wrCtr) < 3 + NUM_PROG);
    zeroWr  = wrEn && (wrSel == '0);
    wDec    = decodeEvt(wrSel[EVT_W-1:0]);
  end

  a_r3_bad_index_errs: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !inRange) |=> wrErr);

  a_r4_unknown_event_errs: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && inRange && wrSel != '0 && !wDec.ok) |=> wrErr);

  a_r2_good_write_no_err: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && inRange && wDec.ok) |=> !wrErr);

  a_r3_err_one_cycle: assert property (@(posedge clk) disable iff (!rstN)
    (wrErr && !$past(wrEn)) |-> 1'b0);

  a_r5_binding_kept: assert property (@(posedge clk) disable iff (!rstN)
    (lookupHit && !zeroWr) |=> ($stable(lookupEvt) |-> (lookupHit && $stable(lookupCtr))));

  a_r9_hit_matches_index: assert property (@(posedge clk) disable iff (!rstN)
    lookupHit == (lookupCtr != '0));

  a_r7_fixed_roles: assert property (@(posedge clk) disable iff (!rstN)
    ((queryCtr == CW'(0)) |-> queryIsCycles) and ((queryCtr == CW'(2)) |-> queryIsInstr));

  a_r8_role_needs_prog: assert property (@(posedge clk) disable iff (!rstN)
    ((queryIsCycles && queryCtr != CW'(0)) || (queryIsInstr && queryCtr != CW'(2)))
      |-> (int'(queryCtr) >= 3 && int'(queryCtr) < 3 + NUM_PROG));

endmodule

bind evt_ctr_mapper evt_ctr_mapper_chk #(
  .MAX_CTRS(MAX_CTRS), .NUM_PROG(NUM_PROG), .SEL_W(SEL_W), .CW(CW)
) chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrCtr(wrCtr), .wrSel(wrSel),
  .wrErr(wrErr), .lookupEvt(lookupEvt), .lookupHit(lookupHit),
  .lookupCtr(lookupCtr), .queryCtr(queryCtr),
  .queryIsCycles(queryIsCycles), .queryIsInstr(queryIsInstr)
);

// File: tb/evt_ctr_mapper_test.sv
module evt_ctr_mapper_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [4:0]  wrCtr = '0;
  logic [31:0] wrSel = '0;
  logic        wrErr;
  logic [19:0] lookupEvt = '0;
  logic        lookupHit;
  logic [4:0]  lookupCtr;
  logic [4:0]  queryCtr = '0;
  logic        queryIsCycles;
  logic        queryIsInstr;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  evt_ctr_mapper uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrCtr(wrCtr), .wrSel(wrSel),
    .wrErr(wrErr), .lookupEvt(lookupEvt), .lookupHit(lookupHit),
    .lookupCtr(lookupCtr), .queryCtr(queryCtr),
    .queryIsCycles(queryIsCycles), .queryIsInstr(queryIsInstr)
  );

  typedef struct packed {
    logic [4:0]  ctr;
    logic [31:0] sel;
    logic [19:0] look;
    logic [4:0]  expCtr;
    logic        expErr;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{5'd3, 32'h00000001, 20'h00001, 5'd3, 1'b0, 4'd2},  // R2 bind cycles
    '{5'd4, 32'h00000001, 20'h00001, 5'd3, 1'b0, 4'd5},  // R5 rebind ignored
    '{5'd4, 32'h00010019, 20'h10019, 5'd4, 1'b0, 4'd2},  // R2 dtlb read
    '{5'd7, 32'h00000002, 20'h00002, 5'd0, 1'b1, 4'd3},  // R3 above range
    '{5'd2, 32'h00000002, 20'h00002, 5'd0, 1'b1, 4'd3},  // R3 fixed index
    '{5'd5, 32'h00010020, 20'h10020, 5'd0, 1'b1, 4'd4},  // R4 unknown code
    '{5'd5, 32'h00000003, 20'h00003, 5'd0, 1'b1, 4'd4},  // R4 unknown code
    '{5'd5, 32'hFFF00002, 20'h00002, 5'd5, 1'b0, 4'd11}, // R11 upper bits
    '{5'd5, 32'h0001001B, 20'h1001B, 5'd5, 1'b0, 4'd10}, // R10 second on ctr5
    '{5'd6, 32'h00010021, 20'h10021, 5'd6, 1'b0, 4'd2},  // R2 itlb
    '{5'd5, 32'h00000000, 20'h1001B, 5'd0, 1'b0, 4'd6},  // R6 clear ctr5
    '{5'd0, 32'h00000000, 20'h00001, 5'd3, 1'b1, 4'd3}   // R3 zero to ctr0
  };

  task automatic check(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic doWrite(input logic [4:0] c, input logic [31:0] s);
    @(negedge clk);
    wrEn = 1'b1; wrCtr = c; wrSel = s;
    @(posedge clk);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic checkLook(input string req, input logic [19:0] e, input logic [4:0] c);
    lookupEvt = e;
    #1;
    check(req, $sformatf("lookup %05h ctr", e), 32'(lookupCtr), 32'(c));
    check(req, $sformatf("lookup %05h hit", e), 32'(lookupHit), 32'(c != 0));
  endtask

  task automatic checkRole(input string req, input logic [4:0] c, input logic cyc,
                           input logic ins);
    queryCtr = c;
    #1;
    check(req, $sformatf("ctr %0d cycles", c), 32'(queryIsCycles), 32'(cyc));
    check(req, $sformatf("ctr %0d instr", c), 32'(queryIsInstr), 32'(ins));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1", "wrErr", 32'(wrErr), 32'd0);
    checkLook("R1", 20'h00001, 5'd0);
    checkLook("R1", 20'h10021, 5'd0);
    for (int c = 3; c <= 6; c++) checkRole("R1", 5'(c), 1'b0, 1'b0);
    checkRole("R7", 5'd0, 1'b1, 1'b0);
    checkRole("R7", 5'd2, 1'b0, 1'b1);

    for (int i = 0; i < NV; i++) begin
      doWrite(VECS[i].ctr, VECS[i].sel);
      check($sformatf("R%0d", VECS[i].req), "wrErr", 32'(wrErr), 32'(VECS[i].expErr));
      checkLook($sformatf("R%0d", VECS[i].req), VECS[i].look, VECS[i].expCtr);
    end

    // R3 error pulse is one cycle long
    @(negedge clk);
    check("R3", "wrErr after idle", 32'(wrErr), 32'd0);

    // R6 clear removed both bindings of ctr5, others kept
    checkLook("R6", 20'h00002, 5'd0);
    checkLook("R6", 20'h10019, 5'd4);
    checkLook("R6", 20'h10021, 5'd6);
    // R9 unsupported identifier misses
    checkLook("R9", 20'h00000, 5'd0);

    // R8 roles follow bindings
    checkRole("R8", 5'd3, 1'b1, 1'b0);
    checkRole("R8", 5'd4, 1'b0, 1'b0);
    checkRole("R8", 5'd5, 1'b0, 1'b0);
    checkRole("R7", 5'd0, 1'b1, 1'b0);

    // R2 rebinding after removal; R8 instr role moves with it
    doWrite(5'd6, 32'h00000002);
    check("R2", "wrErr", 32'(wrErr), 32'd0);
    checkLook("R2", 20'h00002, 5'd6);
    checkRole("R8", 5'd6, 1'b0, 1'b1);
    checkRole("R7", 5'd2, 1'b0, 1'b1);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule